// File: doc/BRIEF.md
# Phase-Framed SPI Slave

This block is an SPI slave for 8-bit words that works in all four clock polarity and phase modes. It oversamples the serial clock, data-in and active-low select in its own system clock domain, assembles each incoming word MSB first, and reports it on `rx_data` with a one-cycle `rx_valid` strobe. Outgoing words come from a one-entry holding register written by the host through `tx_load`. If that register is empty when a word begins, the block sends zero and sets a sticky underrun flag.

How words are framed depends on the phase bit. With phase 0, only one word is accepted per select assertion. After that word the block freezes. It ignores further clocks and does not take new transmit data until select goes high and comes low again. With phase 1, words stream back to back while select stays low. The block reloads its transmit shifter at the first clock edge of every word, and the run ends when select rises. `cfg_cpol` and `cfg_cpha` must stay constant while select is low. The system clock must run at least four times faster than the serial clock.

The controller has three states. ST_IDLE means select is high and MISO is not driven. ST_SHIFT means a word is in progress. ST_FROZEN means a phase-0 word has completed and the block waits for select to rise. The transitions are:
- ST_IDLE→ST_SHIFT on a synchronized falling edge of select.
- ST_SHIFT→ST_FROZEN on the eighth sample when phase is 0.
- ST_SHIFT→ST_IDLE and ST_FROZEN→ST_IDLE whenever the synchronized select is high.
- ST_SHIFT stays in ST_SHIFT across word boundaries when phase is 1.

Top module: `spi_slv_phase`

## Requirements
- R1: The received byte on `rx_data` equals the 8 MOSI bits sent MSB first, in every mode. Mode number = 2*CPOL + CPHA. Phase 0 samples on the leading clock edge. Phase 1 samples on the trailing clock edge.
- R2: The master receives the byte that was in the holding register at word start, MSB first. Phase 0 drives the MSB from the select fall and changes bits on trailing edges. Phase 1 changes bits on leading edges.
- R3: `rx_valid` is high for exactly one system clock per completed word.
- R4: With phase 0, a burst of several words under one select assertion yields exactly one received byte, which is the first. The later clocks do not consume the holding register.
- R5: With phase 1, N words under one select assertion yield N received bytes. The holding register is consumed once per word.
- R6: When select rises before the 8th bit, the partial word is discarded with no `rx_valid`. The next word is received correctly from its first bit.
- R7: `spi_miso_oe` is low while select is deasserted. It drops within three system clocks of select rising.
- R8: A word that starts with an empty holding register sends 0x00 and sets `tx_underrun`. The flag stays set until reset.
- R9: `tx_load` is accepted only when `tx_full` is low, and then sets `tx_full`. A load while full is ignored. When a load and a word start fall in the same cycle on an empty register, the word sends 0x00 and the loaded byte waits for the next word.
- R10: After reset, `rx_valid`, `tx_full`, `tx_underrun` and `spi_miso_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Phase: 0 samples on the leading edge, 1 on the trailing edge |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_csn | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| tx_data | input | 8 | Byte to load into the holding register |
| tx_load | input | 1 | Load strobe for `tx_data` |
| tx_full | output | 1 | Holding register occupied |
| tx_underrun | output | 1 | Sticky flag: a word started with an empty holding register |
| rx_data | output | 8 | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
The host's `tx_load` and the block's word-start take of the holding register can land in the same system clock. The bench provokes this by sweeping the load pulse across every cycle offset after select falls, with the register empty. Each outcome is judged by conservation of the byte. Either the master receives it and `tx_full` ends low, or the master receives 0x00 and `tx_full` stays high, and the following word then delivers the byte.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FROZEN = 2'd2
    } slv_state_e;
endpackage

// File: rtl/spi_slv_sync.sv
// Multi-stage synchronizer for a small vector of asynchronous inputs.
module spi_slv_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_slv_edges.sv
// Leading/trailing clock edge and select-fall detection.
module spi_slv_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic sclk_s,
    input  logic csn_s,
    output logic lead,
    output logic trail,
    output logic cs_fall
);
    logic sclk_d, csn_d;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    assign rise    = sclk_s & ~sclk_d;
    assign fall    = ~sclk_s & sclk_d;
    assign lead    = cpol ? fall : rise;
    assign trail   = cpol ? rise : fall;
    assign cs_fall = csn_d & ~csn_s;
endmodule

// File: rtl/spi_slv_txhold.sv
// One-entry transmit holding register with sticky underrun.
module spi_slv_txhold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] out_data,
    output logic         underrun
);
    logic [W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full     <= 1'b0;
            data_q   <= '0;
            underrun <= 1'b0;
        end else begin
            if (take && full) begin
                full <= 1'b0;
            end else if (ld && !full) begin
                full   <= 1'b1;
                data_q <= ld_data;
            end
            if (take && !full) underrun <= 1'b1;
        end
    end

    assign out_data = full ? data_q : '0;
endmodule

// File: rtl/spi_slv_phase.sv
module spi_slv_phase
    import spi_slv_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_full,
    output logic              tx_underrun,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic              sclk_s, mosi_s, csn_s;
    logic              lead, trail, cs_fall;
    logic              cs_on;
    slv_state_e        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] rx_sh, tx_sh, hold_data;
    logic              take_ph0, start_ph1, take;
    logic              sample_evt, shift_evt, last_bit;

    spi_slv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({spi_csn, spi_mosi, spi_sclk}),
        .q    ({csn_s, mosi_s, sclk_s})
    );

    spi_slv_edges u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .cpol   (cfg_cpol),
        .sclk_s (sclk_s),
        .csn_s  (csn_s),
        .lead   (lead),
        .trail  (trail),
        .cs_fall(cs_fall)
    );

    spi_slv_txhold #(.W(WORD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (tx_load),
        .ld_data (tx_data),
        .take    (take),
        .full    (tx_full),
        .out_data(hold_data),
        .underrun(tx_underrun)
    );

    assign cs_on      = ~csn_s;
    assign last_bit   = (bit_cnt == LAST_BIT);
    // phase 0: transmit word is fixed at select fall
    assign take_ph0   = ~cfg_cpha && (state == ST_IDLE) && cs_fall;
    // phase 1: every word begins at its first leading edge
    assign start_ph1  = cfg_cpha && (state == ST_SHIFT) && cs_on && lead && (bit_cnt == '0);
    assign take       = take_ph0 | start_ph1;
    assign sample_evt = (state == ST_SHIFT) && cs_on && (cfg_cpha ? trail : lead);
    assign shift_evt  = (state == ST_SHIFT) && cs_on &&
                        (cfg_cpha ? (lead && (bit_cnt != '0)) : trail);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (!cs_on)                                   state_nx = ST_IDLE;
                else if (sample_evt && last_bit && !cfg_cpha) state_nx = ST_FROZEN;
            end
            ST_FROZEN: if (!cs_on) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // shifters, counter and received-word outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (take)           tx_sh <= hold_data;
            else if (shift_evt) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};

            if (!cs_on || state != ST_SHIFT) begin
                bit_cnt <= '0;
            end else if (sample_evt) begin
                rx_sh <= {rx_sh[WORD_W-2:0], mosi_s};
                if (last_bit) begin
                    bit_cnt  <= '0;
                    rx_valid <= 1'b1;
                    rx_data  <= {rx_sh[WORD_W-2:0], mosi_s};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // pad outputs
    always_comb begin
        spi_miso    = tx_sh[WORD_W-1];
        spi_miso_oe = (state != ST_IDLE);
    end
endmodule

// File: rtl/spi_slv_phase_chk.sv
module spi_slv_phase_chk
    import spi_slv_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       spi_csn,
    input logic       spi_miso_oe,
    input logic       rx_valid,
    input logic       tx_load,
    input logic       tx_full,
    input logic       tx_underrun,
    input slv_state_e st
);
    a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r7_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_csn, 1) && $past(spi_csn, 2) && $past(spi_csn, 3)) |-> !spi_miso_oe);

    a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_underrun) |-> tx_underrun);

    a_r9_full_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_full) |-> $past(tx_load));

    a_r4_frozen_no_word: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FROZEN && $past(st) == ST_FROZEN) |-> !rx_valid);

    a_r4_frozen_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FROZEN && $past(st) == ST_FROZEN && $past(tx_full)) |-> tx_full);
endmodule

bind spi_slv_phase spi_slv_phase_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_csn    (spi_csn),
    .spi_miso_oe(spi_miso_oe),
    .rx_valid   (rx_valid),
    .tx_load    (tx_load),
    .tx_full    (tx_full),
    .tx_underrun(tx_underrun),
    .st         (state)
);

// File: tb/spi_slv_phase_bench.sv
module spi_slv_phase_bench;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0, cpha = 1'b0;
    logic       sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic       miso, miso_oe;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic       tx_full, tx_underrun, rx_valid;
    logic [7:0] rx_data;

    int checks = 0, errors = 0;

    logic [7:0] f_mo [8];
    logic [7:0] f_mi [8];
    logic [7:0] f_ldv[8];
    bit         f_ld [8];
    int         f_n = 1, f_last_bits = 8, coll_off = -1;
    logic [7:0] coll_val = '0;

    logic [7:0] rx_log [64];
    int         rx_n = 0;

    always #5 clk = ~clk;

    spi_slv_phase u_spi_slv_phase (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe),
        .tx_data(tx_data), .tx_load(tx_load), .tx_full(tx_full),
        .tx_underrun(tx_underrun), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    always @(negedge clk) if (rx_valid) begin
        rx_log[rx_n % 64] = rx_data;
        rx_n++;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hload(input logic [7:0] v);
        tx_data = v; tx_load = 1'b1; tick(1); tx_load = 1'b0;
    endtask

    task automatic set_mode(input int m);
        cpol = m[1]; cpha = m[0]; sclk = m[1]; tick(6);
    endtask

    task automatic half_wait(input int w, input int b);
        if (b == 4 && f_ld[w]) begin hload(f_ldv[w]); tick(HALF - 1); end
        else tick(HALF);
    endtask

    task automatic run_frame();
        csn = 1'b0;
        for (int t = 0; t < HALF; t++) begin
            if (t == coll_off) hload(coll_val);
            else tick(1);
        end
        for (int w = 0; w < f_n; w++) begin
            int nb = (w == f_n - 1) ? f_last_bits : 8;
            for (int b = 0; b < nb; b++) begin
                int i = 7 - b;
                if (!cpha) begin
                    mosi = f_mo[w][i]; half_wait(w, b);
                    f_mi[w][i] = miso; sclk = ~cpol; tick(HALF); sclk = cpol;
                end else begin
                    sclk = ~cpol; mosi = f_mo[w][i]; half_wait(w, b);
                    sclk = cpol; f_mi[w][i] = miso; tick(HALF);
                end
            end
        end
        tick(HALF); csn = 1'b1; tick(3 * HALF);
        coll_off = -1; f_last_bits = 8;
    endtask

    function automatic int exp_words(input bit ph, input int n);
        return ph ? n : 1;
    endfunction

    task automatic clear_frame();
        for (int k = 0; k < 8; k++) begin f_ld[k] = 0; f_ldv[k] = '0; f_mo[k] = '0; end
    endtask

    initial begin
        int unsigned seed;
        int base;
        logic [7:0] tx_b [8];
        seed = $urandom(32'h5EED_0001);
        clear_frame();
        tick(4);
        // R10 reset state
        chk(rx_valid == 0 && tx_full == 0 && tx_underrun == 0 && miso_oe == 0, "R10",
            {rx_valid, tx_full, tx_underrun, miso_oe}, 0);
        rst_n = 1'b1; tick(4);
        chk(miso_oe == 0 && tx_full == 0, "R10", {miso_oe, tx_full}, 0);

        // R4 mode 0 burst under one select: only first word, held byte untouched
        set_mode(0); clear_frame();
        f_n = 4; f_mo[0] = 8'h5A; f_mo[1] = 8'h5A; f_mo[2] = 8'hA5; f_mo[3] = 8'hA5;
        f_ld[0] = 1; f_ldv[0] = 8'h3C;
        hload(8'hC3);
        base = rx_n; run_frame();
        chk(rx_n - base == 1, "R4", rx_n - base, 1);
        chk(rx_log[base % 64] == 8'h5A, "R4", rx_log[base % 64], 8'h5A);
        chk(f_mi[0] == 8'hC3, "R2", f_mi[0], 8'hC3);
        chk(tx_full == 1, "R4", tx_full, 1);
        chk(miso_oe == 0, "R7", miso_oe, 0);
        clear_frame(); f_n = 1; f_mo[0] = 8'h81;
        base = rx_n; run_frame();
        chk(f_mi[0] == 8'h3C, "R4", f_mi[0], 8'h3C);
        chk(rx_log[base % 64] == 8'h81, "R1", rx_log[base % 64], 8'h81);

        // random frames in all modes
        for (int it = 0; it < 40; it++) begin
            int m = $urandom_range(3, 0);
            int n = $urandom_range(4, 1);
            set_mode(m); clear_frame(); f_n = n;
            for (int k = 0; k < n; k++) begin f_mo[k] = 8'($urandom); tx_b[k] = 8'($urandom); end
            if (m[0]) for (int k = 0; k < n - 1; k++) begin f_ld[k] = 1; f_ldv[k] = tx_b[k + 1]; end
            hload(tx_b[0]);
            base = rx_n; run_frame();
            chk(rx_n - base == exp_words(m[0], n), m[0] ? "R5" : "R4", rx_n - base, exp_words(m[0], n));
            for (int k = 0; k < exp_words(m[0], n); k++) begin
                chk(rx_log[(base + k) % 64] == f_mo[k], "R1", rx_log[(base + k) % 64], f_mo[k]);
                chk(f_mi[k] == tx_b[k], "R2", f_mi[k], tx_b[k]);
            end
            chk(tx_full == 0, m[0] ? "R5" : "R2", tx_full, 0);
        end
        chk(tx_underrun == 0, "R8", tx_underrun, 0);

        // R6 abort mid-word (mode 1), then a clean word
        set_mode(1); clear_frame(); f_n = 1; f_mo[0] = 8'hF0; f_last_bits = 4;
        hload(8'h11);
        base = rx_n; run_frame();
        chk(rx_n - base == 0, "R6", rx_n - base, 0);
        chk(miso_oe == 0, "R7", miso_oe, 0);
        clear_frame(); f_n = 1; f_mo[0] = 8'h96; hload(8'h69);
        base = rx_n; run_frame();
        chk(rx_n - base == 1 && rx_log[base % 64] == 8'h96, "R6", rx_log[base % 64], 8'h96);
        chk(f_mi[0] == 8'h69, "R6", f_mi[0], 8'h69);

        // R9 load while full ignored; R8 underrun sends zero
        set_mode(2); clear_frame(); f_n = 1; f_mo[0] = 8'h24;
        hload(8'hAA); hload(8'hBB);
        run_frame();
        chk(f_mi[0] == 8'hAA, "R9", f_mi[0], 8'hAA);
        chk(tx_full == 0 && tx_underrun == 0, "R9", {tx_full, tx_underrun}, 0);
        base = rx_n; run_frame();
        chk(f_mi[0] == 8'h00, "R8", f_mi[0], 0);
        chk(tx_underrun == 1, "R8", tx_underrun, 1);
        chk(rx_log[base % 64] == 8'h24, "R1", rx_log[base % 64], 8'h24);
        set_mode(3); hload(8'h77); run_frame();
        chk(f_mi[0] == 8'h77 && tx_underrun == 1, "R8", f_mi[0], 8'h77);

        // R9 load colliding with the word-start take, swept over offsets
        for (int off = 0; off < HALF; off++) begin
            logic [7:0] cv = 8'hC0 + 8'(off);
            set_mode(0); clear_frame(); f_n = 1; f_mo[0] = 8'h0F;
            coll_off = off; coll_val = cv;
            run_frame();
            if (f_mi[0] == cv) begin
                chk(tx_full == 0, "R9", tx_full, 0);
            end else begin
                chk(f_mi[0] == 8'h00 && tx_full == 1, "R9", f_mi[0], cv);
                run_frame();
                chk(f_mi[0] == cv, "R9", f_mi[0], cv);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule